// File: doc/BRIEF.md
# Sample Phase Tuning Selector

This block finds a good receive sampling phase for a card interface whose capture point can be moved in eight steps. A single start pulse launches a sweep. The sweep begins at the step after the phase now in use and visits every step exactly once, so it ends on the phase it started from. For each step the block presents a phase and raises a request for one cycle. It also asks for the data timeout to be held at its maximum so that a failing trial runs to the end instead of stopping early. An outside agent performs the trial and answers with a done strobe and a pass flag.

Once the last trial is in, the passing steps form a circular 8-bit map. The block first looks for the lowest step whose two neighbours on each side also passed. Failing that, it looks for the lowest step with one passing neighbour on each side. Failing that, it takes the lowest passing step. The search walks one candidate per cycle through each rank in turn. The chosen step is loaded into a result register and a done pulse is issued. If no step passed, the error flag rises and the result goes back to the phase the sweep started from.

Top module: `phase_tune`

## Requirements
- R1: After start, trial phases run in the order cur+1, cur+2, ... modulo 8, and the eighth trial is at cur itself, where cur is `cur_phase_i` sampled with the start pulse.
- R2: Each trial raises `trial_req_o` for exactly one cycle, and no new request appears until `trial_done_i` has been seen for the current one.
- R3: `tmo_max_o` is high from the request cycle of a trial until the cycle its done strobe is taken, for every trial.
- R4: A trial reported with `trial_pass_i`=1 marks the phase that was tried as passing. A failed trial leaves that phase unmarked. The map is cleared at each start.
- R5: If any phase p has phases p-2, p-1, p, p+1 and p+2 (circular) all passing, the lowest such p is chosen.
- R6: Otherwise, if any p has p-1, p and p+1 all passing, the lowest such p is chosen.
- R7: Otherwise the lowest passing phase is chosen.
- R8: If no phase passed, `done_o` pulses, `err_o` is 1, and `phase_o` equals the phase the sweep started from.
- R9: On success `phase_o` shows the chosen phase and `err_o` is 0. `done_o` is high for one cycle. `phase_o` changes only together with `done_o` and then holds.
- R10: A start pulse during a sweep is ignored: the trial order and the result are unaffected.
- R11: Reset puts the block in idle with `trial_req_o`, `tmo_max_o`, `done_o`, `err_o` and `phase_o` all 0, and clears the pass map.
- R12: `done_o` rises no more than 24 cycles after the clock edge that takes the last done strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a sweep (taken only when idle) |
| cur_phase_i | input | 3 | Sample phase in use when the sweep starts |
| trial_req_o | output | 1 | One-cycle request to run a trial |
| trial_phase_o | output | 3 | Phase to apply for the current trial |
| tmo_max_o | output | 1 | Hold data timeout at maximum during a trial |
| trial_done_i | input | 1 | Trial finished strobe |
| trial_pass_i | input | 1 | Trial result, valid with trial_done_i |
| phase_o | output | 3 | Tuned phase result |
| done_o | output | 1 | One-cycle pulse when a sweep ends |
| err_o | output | 1 | No phase passed in the last sweep |

## Verification
The hardest case to reach from the ports is a pass map where the ranks compete. For example, one map holds both a three-wide run at a lower centre and a five-wide run at a higher one, and another holds a five-wide run that wraps across phase 0. Reaching these needs a full eight-trial handshake with pass flags chosen per phase. The stimulus table therefore lists, for each sweep, the start phase, the pass map and the reply latency. A responder task answers every request from that map. A poke option injects a second start pulse in the middle of a sweep.

// File: rtl/phase_tune_pkg.sv
package phase_tune_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_SRCH = 2'd3
  } tune_state_e;
endpackage

// File: rtl/phase_tune_mask.sv
module phase_tune_mask #(
  parameter int PHASE_W = 3,
  localparam int N = 1 << PHASE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic               set_i,
  input  logic [PHASE_W-1:0] bit_i,
  output logic [N-1:0]       mask_o
);
  logic [N-1:0] mask_q, mask_n;

  always_comb begin
    mask_n = mask_q;
    if (clr_i)      mask_n = '0;
    else if (set_i) mask_n[bit_i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              mask_q <= '0;
    else if (clr_i || set_i) mask_q <= mask_n;
  end

  assign mask_o = mask_q;

  // R4: a clear empties the map on the next cycle
  p_mask_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (mask_o == '0));
  // R4: a marked phase stays marked until the next clear
  p_mask_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && mask_o[bit_i]) |=> mask_o[$past(bit_i)]);
endmodule

// File: rtl/phase_tune_window.sv
module phase_tune_window #(
  parameter int PHASE_W  = 3,
  parameter int WIN_HALF = 2,
  localparam int N     = 1 << PHASE_W,
  localparam int LVLS  = WIN_HALF + 1,
  localparam int LVL_W = (LVLS > 1) ? $clog2(LVLS) : 1
) (
  input  logic [N-1:0]       mask_i,
  input  logic [PHASE_W-1:0] ctr_i,
  input  logic [LVL_W-1:0]   lvl_i,
  output logic               hit_o
);
  logic [2*N-1:0] dbl;
  logic [N-1:0]   rot;
  logic [LVLS-1:0] hit_v;

  assign dbl = {mask_i, mask_i};
  assign rot = dbl[ctr_i +: N];

  // rank lv checks a circular window of half-width WIN_HALF-lv around ctr_i
  for (genvar lv = 0; lv < LVLS; lv++) begin : g_lvl
    localparam int H = WIN_HALF - lv;
    if (H == 0) begin : g_single
      assign hit_v[lv] = rot[0];
    end else begin : g_wide
      assign hit_v[lv] = (&rot[H:0]) & (&rot[N-1:N-H]);
    end
  end

  always_comb begin
    hit_o = 1'b0;
    for (int k = 0; k < LVLS; k++)
      if (lvl_i == LVL_W'(k)) hit_o = hit_v[k];
  end
endmodule

// File: rtl/phase_tune_search.sv
module phase_tune_search #(
  parameter int PHASE_W  = 3,
  parameter int WIN_HALF = 2,
  localparam int N     = 1 << PHASE_W,
  localparam int LVLS  = WIN_HALF + 1,
  localparam int LVL_W = (LVLS > 1) ? $clog2(LVLS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go_i,
  input  logic               en_i,
  input  logic [N-1:0]       mask_i,
  output logic               hit_o,
  output logic               last_o,
  output logic [PHASE_W-1:0] sel_o
);
  logic [PHASE_W-1:0] ctr_q, ctr_n;
  logic [LVL_W-1:0]   lvl_q, lvl_n;
  logic               step;

  phase_tune_window #(.PHASE_W(PHASE_W), .WIN_HALF(WIN_HALF)) u_win (
    .mask_i (mask_i),
    .ctr_i  (ctr_q),
    .lvl_i  (lvl_q),
    .hit_o  (hit_o)
  );

  assign last_o = (ctr_q == PHASE_W'(N-1)) && (lvl_q == LVL_W'(LVLS-1));
  assign step   = go_i || (en_i && !hit_o && !last_o);

  always_comb begin
    ctr_n = ctr_q;
    lvl_n = lvl_q;
    if (go_i) begin
      ctr_n = '0;
      lvl_n = '0;
    end else if (ctr_q == PHASE_W'(N-1)) begin
      ctr_n = '0;
      lvl_n = LVL_W'(lvl_q + 1'b1);
    end else begin
      ctr_n = PHASE_W'(ctr_q + 1'b1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctr_q <= '0;
      lvl_q <= '0;
    end else if (step) begin
      ctr_q <= ctr_n;
      lvl_q <= lvl_n;
    end
  end

  assign sel_o = ctr_q;

  // R12: the rank counter never leaves its range, bounding the search
  p_rank_range_r12: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q < LVL_W'(LVLS));
  // R12: a search step always moves the candidate forward
  p_search_moves_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !go_i && !hit_o && !last_o) |=> !$stable({lvl_q, ctr_q}));
endmodule

// File: rtl/phase_tune.sv
module phase_tune #(
  parameter int PHASE_W  = 3,
  parameter int WIN_HALF = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [PHASE_W-1:0] cur_phase_i,
  output logic               trial_req_o,
  output logic [PHASE_W-1:0] trial_phase_o,
  output logic               tmo_max_o,
  input  logic               trial_done_i,
  input  logic               trial_pass_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic               done_o,
  output logic               err_o
);
  import phase_tune_pkg::*;
  localparam int N = 1 << PHASE_W;

  tune_state_e        st_q, st_n;
  logic [PHASE_W-1:0] start_q, start_n;
  logic [PHASE_W-1:0] trial_q, trial_n;
  logic [PHASE_W-1:0] phase_q, phase_n;
  logic               done_q, done_n;
  logic               err_q, err_n;
  logic               mask_clr, mask_set, srch_go, srch_en;
  logic               hit, last;
  logic [PHASE_W-1:0] sel;
  logic [N-1:0]       mask;

  phase_tune_mask #(.PHASE_W(PHASE_W)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (mask_clr),
    .set_i  (mask_set),
    .bit_i  (trial_q),
    .mask_o (mask)
  );

  phase_tune_search #(.PHASE_W(PHASE_W), .WIN_HALF(WIN_HALF)) u_search (
    .clk    (clk),
    .rst_n  (rst_n),
    .go_i   (srch_go),
    .en_i   (srch_en),
    .mask_i (mask),
    .hit_o  (hit),
    .last_o (last),
    .sel_o  (sel)
  );

  always_comb begin
    st_n     = st_q;
    start_n  = start_q;
    trial_n  = trial_q;
    phase_n  = phase_q;
    done_n   = 1'b0;
    err_n    = err_q;
    mask_clr = 1'b0;
    mask_set = 1'b0;
    srch_go  = 1'b0;
    srch_en  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        start_n  = cur_phase_i;
        trial_n  = PHASE_W'(cur_phase_i + 1'b1);
        mask_clr = 1'b1;
        err_n    = 1'b0;
        st_n     = ST_REQ;
      end
      ST_REQ: st_n = ST_WAIT;
      ST_WAIT: if (trial_done_i) begin
        mask_set = trial_pass_i;
        if (trial_q == start_q) begin
          srch_go = 1'b1;
          st_n    = ST_SRCH;
        end else begin
          trial_n = PHASE_W'(trial_q + 1'b1);
          st_n    = ST_REQ;
        end
      end
      ST_SRCH: begin
        srch_en = 1'b1;
        if (hit) begin
          phase_n = sel;
          done_n  = 1'b1;
          st_n    = ST_IDLE;
        end else if (last) begin
          phase_n = start_q;
          err_n   = 1'b1;
          done_n  = 1'b1;
          st_n    = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      start_q <= '0;
      trial_q <= '0;
      phase_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_n;
      start_q <= start_n;
      trial_q <= trial_n;
      phase_q <= phase_n;
      done_q  <= done_n;
      err_q   <= err_n;
    end
  end

  assign trial_req_o   = (st_q == ST_REQ);
  assign tmo_max_o     = (st_q == ST_REQ) || (st_q == ST_WAIT);
  assign trial_phase_o = trial_q;
  assign phase_o       = phase_q;
  assign done_o        = done_q;
  assign err_o         = err_q;

  // R2: a request lasts one cycle
  p_req_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trial_req_o |=> !trial_req_o);
  // R3: timeout is forced whenever a trial is requested
  p_tmo_with_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trial_req_o |-> tmo_max_o);
  // R9: done is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R9: the result moves only together with done
  p_phase_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(phase_o) |-> done_o);
  // R10: a start while a trial is pending leaves the trial phase alone
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_max_o && start_i && !trial_done_i) |=> $stable(trial_phase_o));
  // R8: done and request never coincide
  p_done_no_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !tmo_max_o);
endmodule

// File: tb/phase_tune_tb.sv
`timescale 1ns/1ps
module phase_tune_tb;
  logic       clk, rst_n, start_i, trial_done_i, trial_pass_i;
  logic [2:0] cur_phase_i;
  logic       trial_req_o, tmo_max_o, done_o, err_o;
  logic [2:0] trial_phase_o, phase_o;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  phase_tune u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cur_phase_i(cur_phase_i),
    .trial_req_o(trial_req_o), .trial_phase_o(trial_phase_o),
    .tmo_max_o(tmo_max_o), .trial_done_i(trial_done_i),
    .trial_pass_i(trial_pass_i), .phase_o(phase_o), .done_o(done_o),
    .err_o(err_o)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  // {latency[3:0], poke, start[2:0], pass map[7:0]}
  localparam logic [15:0] VEC [10] = '{
    {4'd1, 1'b0, 3'd3, 8'hFF},
    {4'd2, 1'b1, 3'd0, 8'h7C},
    {4'd1, 1'b0, 3'd5, 8'h83},
    {4'd3, 1'b0, 3'd6, 8'h0E},
    {4'd1, 1'b0, 3'd1, 8'h50},
    {4'd1, 1'b0, 3'd6, 8'h00},
    {4'd2, 1'b0, 3'd2, 8'hE3},
    {4'd1, 1'b0, 3'd4, 8'h80},
    {4'd2, 1'b1, 3'd7, 8'hF8},
    {4'd1, 1'b0, 3'd0, 8'h01}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rotr(input logic [7:0] m, input int s);
    logic [7:0] r = m;
    for (int k = 0; k < s; k++) r = {r[0], r[7:1]};
    return r;
  endfunction

  // expected choice and rank (0 five-wide, 1 three-wide, 2 single, -1 none)
  function automatic void pick(input logic [7:0] m, output int ph, output int rank);
    logic [7:0] pat [3] = '{8'hC7, 8'h83, 8'h01};
    ph = -1; rank = -1;
    for (int lv = 0; lv < 3 && ph < 0; lv++)
      for (int i = 0; i < 8 && ph < 0; i++)
        if ((rotr(m, i) & pat[lv]) == pat[lv]) begin ph = i; rank = lv; end
  endfunction

  task automatic run_sweep(input int lat, input bit poke, input int st, input logic [7:0] m);
    int exp, rank, n, ph;
    pick(m, exp, rank);
    @(negedge clk); start_i = 1; cur_phase_i = 3'(st);
    @(negedge clk); start_i = 0;
    for (int t = 0; t < 8; t++) begin
      ph = (st + 1 + t) % 8;
      n = 0;
      while (!trial_req_o && n < 20) begin @(negedge clk); n++; end
      chk(trial_req_o && trial_phase_o == 3'(ph), "R1 trial order", trial_phase_o, ph);
      chk(tmo_max_o == 1'b1, "R3 timeout forced at request", tmo_max_o, 1);
      for (int w = 0; w <= lat; w++) begin
        @(negedge clk);
        if (poke && t == 3 && w == 0) begin start_i = 1; cur_phase_i = 3'(st + 4); end
        if (w == 1) start_i = 0;
        chk(!trial_req_o, "R2 no request while waiting", trial_req_o, 0);
        chk(tmo_max_o, "R3 timeout held while waiting", tmo_max_o, 1);
      end
      start_i = 0;
      trial_done_i = 1; trial_pass_i = m[ph];
      @(negedge clk); trial_done_i = 0; trial_pass_i = 0;
    end
    n = 0;
    while (!done_o && n < 40) begin @(negedge clk); n++; end
    chk(done_o && n <= 24, "R12 result latency", n, 24);
    if (exp < 0) begin
      chk(err_o == 1'b1, "R8 error flag", err_o, 1);
      chk(phase_o == 3'(st), "R8 phase unchanged", phase_o, st);
    end else begin
      chk(err_o == 1'b0, "R9 no error", err_o, 0);
      case (rank)
        0: chk(phase_o == 3'(exp), "R5/R4 five-wide choice", phase_o, exp);
        1: chk(phase_o == 3'(exp), "R6/R4 three-wide choice", phase_o, exp);
        default: chk(phase_o == 3'(exp), "R7/R4 single choice", phase_o, exp);
      endcase
      if (poke) chk(phase_o == 3'(exp), "R10 start ignored mid-sweep", phase_o, exp);
    end
    @(negedge clk);
    chk(!done_o, "R9 done one cycle", done_o, 0);
    chk(phase_o == 3'((exp < 0) ? st : exp), "R9 result held", phase_o, (exp < 0) ? st : exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start_i = 0; cur_phase_i = 0; trial_done_i = 0; trial_pass_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk({trial_req_o, tmo_max_o, done_o, err_o} == 4'b0, "R11 reset outputs",
        {trial_req_o, tmo_max_o, done_o, err_o}, 0);
    chk(phase_o == 3'd0, "R11 reset phase", phase_o, 0);

    foreach (VEC[v])
      run_sweep(int'(VEC[v][15:12]), VEC[v][11], int'(VEC[v][10:8]), VEC[v][7:0]);

    // R11 reset in the middle of a sweep
    @(negedge clk); start_i = 1; cur_phase_i = 3'd2;
    @(negedge clk); start_i = 0;
    repeat (2) @(negedge clk);
    rst_n = 0;
    #1;
    chk({trial_req_o, tmo_max_o, done_o, err_o} == 4'b0, "R11 mid-sweep reset outputs",
        {trial_req_o, tmo_max_o, done_o, err_o}, 0);
    chk(phase_o == 3'd0, "R11 mid-sweep reset phase", phase_o, 0);
    @(negedge clk); rst_n = 1;
    begin
      int reqs = 0;
      for (int c = 0; c < 6; c++) begin @(negedge clk); reqs += int'(tmo_max_o); end
      chk(reqs == 0, "R11 idle after reset", reqs, 0);
    end
    // after reset a sweep where only phase 3 passes must pick 3 (map cleared)
    run_sweep(1, 1'b0, 5, 8'h08);

    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule